// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block joins two half-duplex, open-drain data lines: one facing a host controller and one facing a card. Each side is seen as a level input plus two enables, one that pulls the line low and one that briefly strengthens the pull-up. Whichever side falls first is the master for that transfer. Its low level is copied to the other side, the slave, after a delay of `TD_CYCLES` system clocks. The slave side is not watched while it is being driven, so the block cannot lock onto its own output. When the master lets go, the slave drive is removed and the slave pull-up is boosted for `TD_CYCLES` cycles. The block then returns to rest.

A chip select isolates the host side: the host enables are forced off and the host input is read as high. Outside an active session, the card line is held low. Both line inputs pass through a `SYNC_STAGES`-flop synchronizer and a falling-edge detector before they reach the controller. A chip uses three copies of the block: one for the data line and two for auxiliary lines.

The controller has nine states. `ST_OFF` holds the card low and is entered from any state when the session input is low. It moves to `ST_IDLE` when the session input goes high. From `ST_IDLE`, a lone host fall leads to `ST_H_WAIT`, a lone card fall leads to `ST_C_WAIT`, and falls on both sides in the same cycle lead to `ST_CLASH`. Each wait state goes back to `ST_IDLE` if the master rises early, and otherwise goes to its hold state (`ST_H_HOLD` or `ST_C_HOLD`) once the delay ends. A hold state goes to its boost state (`ST_H_BOOST` or `ST_C_BOOST`) when the master rises. A boost state ends after the delay, going to `ST_IDLE` if both lines are high and to `ST_CLASH` if not. `ST_CLASH` drives nothing and goes to `ST_IDLE` once both lines read high.

Top module: `od_line_repeater`

## Requirements
- R1: During reset, and for as long as `session_en` is low, `card_drive_low` is 1 and `host_drive_low`, `host_boost` and `card_boost` are 0.
- R2: At rest in an active session, with both lines high, all four output enables are 0.
- R3: When the host line falls first, `card_drive_low` goes to 1 at the (TD_CYCLES+3)th rising clock edge, counting as edge 1 the first edge at which the low is present on `host_in`.
- R4: When the card line falls first, `host_drive_low` goes to 1 with the same latency as in R3 (chip select high).
- R5: While one side is master, that side's drive enable stays 0, and a low on the slave side never starts a transfer in the opposite direction.
- R6: Counting as edge 1 the first edge at which the master input is high again, the slave drive enable goes to 0 and the slave boost goes to 1 at edge 3. The boost stays on for exactly TD_CYCLES cycles and is never asserted together with drive_low on the same side.
- R7: A master low that ends before the copy delay expires is not copied, and no boost follows it.
- R8: When both sides fall in the same cycle, neither side is driven or boosted until both lines read high. After that, a new transfer is accepted.
- R9: If the slave line is still held low from outside when the boost ends, nothing is driven, further falls are ignored, and normal operation resumes once both lines are high.
- R10: With `chip_sel` low, `host_drive_low` and `host_boost` are 0 and a low on `host_in` is ignored.
- R11: One cycle after `session_en` is sampled low, `card_drive_low` is 1 and stays 1 while `session_en` is low, whatever the lines do. After `session_en` returns high, the block comes back to rest.
- R12: Transfers in either direction can follow one another back to back. After each one completes, the next falling edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| session_en | input | 1 | High while a card session is active |
| chip_sel | input | 1 | High enables the host side |
| host_in | input | 1 | Sampled level of the host-side line |
| card_in | input | 1 | Sampled level of the card-side line |
| host_drive_low | output | 1 | Pull the host-side line low |
| host_boost | output | 1 | Active pull-up boost on the host-side line |
| card_drive_low | output | 1 | Pull the card-side line low |
| card_boost | output | 1 | Active pull-up boost on the card-side line |

## Verification
Transfers are started from each side in turn, with random low durations and random gaps. This separates the copy latency from the release-boost timing and shows that the master side is never driven back. A low shorter than the delay shows that glitches are not copied. Simultaneous falls and a slave held low through the boost exercise the two ways into `ST_CLASH`, and a follow-on transfer confirms recovery from each. Chip select low and a session drop in mid-transfer show that isolation and the card hold-low override whatever the controller was doing.

// File: rtl/od_rep_pkg.sv
package od_rep_pkg;
    typedef enum logic [3:0] {
        ST_OFF,
        ST_IDLE,
        ST_H_WAIT,
        ST_H_HOLD,
        ST_H_BOOST,
        ST_C_WAIT,
        ST_C_HOLD,
        ST_C_BOOST,
        ST_CLASH
    } rep_state_t;
endpackage

// File: rtl/od_sync.sv
module od_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Reset to high: an idle open-drain line rests high.
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '1;
        else        chain[0] <= d;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '1;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/od_fall_detect.sv
module od_fall_detect #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '1;
        else        level_q <= level;
    end

    assign fall = level_q & ~level;
endmodule

// File: rtl/od_span_timer.sv
module od_span_timer #(
    parameter int unsigned SPAN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic done
);
    localparam int unsigned CW = $clog2(SPAN + 1);

    logic [CW-1:0] cnt;

    // done is high in the last cycle of a SPAN-cycle window opened by clear.
    assign done = (cnt == CW'(SPAN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (!done) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/od_line_repeater.sv
module od_line_repeater
    import od_rep_pkg::*;
#(
    parameter int unsigned TD_CYCLES   = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic session_en,
    input  logic chip_sel,
    input  logic host_in,
    input  logic card_in,
    output logic host_drive_low,
    output logic host_boost,
    output logic card_drive_low,
    output logic card_boost
);
    // The boost window must outlast the synchronizer latency, so that the
    // released slave line has been seen high again when the boost ends.
    localparam int unsigned SPAN = (TD_CYCLES < SYNC_STAGES + 1) ? SYNC_STAGES + 1 : TD_CYCLES;

    rep_state_t state_q, state_d;
    logic host_seen, host_s, card_s, host_fall, card_fall, span_done;
    logic host_drv_raw, host_bst_raw;

    // A deselected host side reads as released.
    assign host_seen = chip_sel ? host_in : 1'b1;

    od_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_seen, card_in}),
        .q     ({host_s, card_s})
    );

    od_fall_detect #(.WIDTH(2)) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({host_s, card_s}),
        .fall  ({host_fall, card_fall})
    );

    od_span_timer #(.SPAN(SPAN)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_d != state_q),
        .done  (span_done)
    );

    always_comb begin
        state_d = state_q;
        if (!session_en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_IDLE;
                ST_IDLE: begin
                    if (host_fall && card_fall) state_d = ST_CLASH;
                    else if (host_fall)         state_d = ST_H_WAIT;
                    else if (card_fall)         state_d = ST_C_WAIT;
                end
                ST_H_WAIT: begin
                    if (host_s)         state_d = ST_IDLE;
                    else if (span_done) state_d = ST_H_HOLD;
                end
                ST_H_HOLD:  if (host_s) state_d = ST_H_BOOST;
                ST_H_BOOST: if (span_done) state_d = (host_s && card_s) ? ST_IDLE : ST_CLASH;
                ST_C_WAIT: begin
                    if (card_s)         state_d = ST_IDLE;
                    else if (span_done) state_d = ST_C_HOLD;
                end
                ST_C_HOLD:  if (card_s) state_d = ST_C_BOOST;
                ST_C_BOOST: if (span_done) state_d = (host_s && card_s) ? ST_IDLE : ST_CLASH;
                ST_CLASH:   if (host_s && card_s) state_d = ST_IDLE;
                default:    state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        card_drive_low = 1'b0;
        card_boost     = 1'b0;
        host_drv_raw   = 1'b0;
        host_bst_raw   = 1'b0;
        unique case (state_q)
            ST_OFF:     card_drive_low = 1'b1;
            ST_H_HOLD:  card_drive_low = 1'b1;
            ST_H_BOOST: card_boost     = 1'b1;
            ST_C_HOLD:  host_drv_raw   = 1'b1;
            ST_C_BOOST: host_bst_raw   = 1'b1;
            default:    ;
        endcase
    end

    assign host_drive_low = host_drv_raw & chip_sel;
    assign host_boost     = host_bst_raw & chip_sel;

    // R5: the two sides are never driven low at the same time
    p_one_driver_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_drive_low && card_drive_low));

    // R6: boost and drive never overlap on the card side
    p_no_boost_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_boost && card_drive_low));

    // R6: a card boost is always preceded by a card drive
    p_boost_after_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_boost) |-> $past(card_drive_low));

    // R3: a copy onto the card starts only while the host is seen low
    p_copy_needs_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(card_drive_low) && $past(session_en)) |-> $past(!host_s));

    // R11: session off forces the card line low on the next cycle
    p_off_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !session_en |=> card_drive_low);
endmodule

// File: tb/tb_od_line_repeater.sv
module tb_od_line_repeater;
    localparam int TD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic session_en = 1'b0;
    logic chip_sel = 1'b1;
    logic host_ext = 1'b0;
    logic card_ext = 1'b0;
    logic host_in, card_in;
    logic host_drive_low, host_boost, card_drive_low, card_boost;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // Open-drain wires: low if anyone pulls them low.
    assign host_in = !(host_drive_low || host_ext);
    assign card_in = !(card_drive_low || card_ext);

    od_line_repeater #(.TD_CYCLES(TD)) dut (
        .clk(clk), .rst_n(rst_n), .session_en(session_en), .chip_sel(chip_sel),
        .host_in(host_in), .card_in(card_in),
        .host_drive_low(host_drive_low), .host_boost(host_boost),
        .card_drive_low(card_drive_low), .card_boost(card_boost)
    );

    function automatic int exp_copy_lat(int td); return td + 3; endfunction
    function automatic int exp_boost_start(); return 3; endfunction
    function automatic int exp_boost_len(int td); return td; endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int outs();
        return {28'd0, host_drive_low, host_boost, card_drive_low, card_boost};
    endfunction

    task automatic transfer(input bit from_host, input int len, input string tag);
        int first_drv = 0, first_bst = 0, bst_n = 0;
        bit master_hit = 0, overlap = 0;
        @(negedge clk);
        if (from_host) host_ext = 1'b1; else card_ext = 1'b1;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (first_drv == 0 && (from_host ? card_drive_low : host_drive_low)) first_drv = i;
            if (from_host ? host_drive_low : card_drive_low) master_hit = 1;
        end
        check(first_drv == exp_copy_lat(TD), {tag, " copy latency"}, first_drv, exp_copy_lat(TD));
        check(!master_hit, "R5 master side driven", master_hit, 0);
        if (from_host) host_ext = 1'b0; else card_ext = 1'b0;
        for (int i = 1; i <= TD + 8; i++) begin
            @(negedge clk);
            if (from_host ? card_boost : host_boost) begin
                bst_n++;
                if (first_bst == 0) first_bst = i;
                if (from_host ? card_drive_low : host_drive_low) overlap = 1;
            end
        end
        check(first_bst == exp_boost_start(), "R6 boost start", first_bst, exp_boost_start());
        check(bst_n == exp_boost_len(TD), "R6 boost length", bst_n, exp_boost_len(TD));
        check(!overlap, "R6 boost with drive", overlap, 0);
        check(outs() == 0, "R12 rest after transfer", outs(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit hit;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(outs() == 4'b0010, "R1 reset outputs", outs(), 4'b0010);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(outs() == 4'b0010, "R1 session off outputs", outs(), 4'b0010);
        session_en = 1'b1;
        repeat (4) @(negedge clk);
        check(outs() == 0, "R2 rest outputs", outs(), 0);

        transfer(1'b1, TD + 20, "R3");
        transfer(1'b0, TD + 20, "R4");

        // R7: short host pulse is dropped
        @(negedge clk); host_ext = 1'b1;
        repeat (3) @(negedge clk); host_ext = 1'b0;
        hit = 0;
        for (int i = 0; i < 3 * TD; i++) begin
            @(negedge clk);
            if (card_drive_low || card_boost) hit = 1;
        end
        check(!hit, "R7 short pulse copied", hit, 0);

        // R8: simultaneous falls
        @(negedge clk); host_ext = 1'b1; card_ext = 1'b1;
        hit = 0;
        for (int i = 0; i < 4 * TD; i++) begin
            @(negedge clk);
            if (outs() != 0) hit = 1;
        end
        check(!hit, "R8 conflict drove", hit, 0);
        host_ext = 1'b0;
        hit = 0;
        for (int i = 0; i < 2 * TD; i++) begin
            @(negedge clk);
            if (outs() != 0) hit = 1;
        end
        check(!hit, "R8 one side released", hit, 0);
        card_ext = 1'b0;
        repeat (5) @(negedge clk);
        transfer(1'b1, TD + 8, "R8 recovery");

        // R9: card still held low when the boost ends
        @(negedge clk); host_ext = 1'b1;
        repeat (TD + 6) @(negedge clk);
        card_ext = 1'b1;
        repeat (4) @(negedge clk);
        host_ext = 1'b0;
        repeat (TD + 10) @(negedge clk);
        check(outs() == 0, "R9 after late conflict", outs(), 0);
        host_ext = 1'b1;
        hit = 0;
        for (int i = 0; i < 3 * TD; i++) begin
            @(negedge clk);
            if (outs() != 0) hit = 1;
        end
        check(!hit, "R9 fall ignored in conflict", hit, 0);
        host_ext = 1'b0; card_ext = 1'b0;
        repeat (5) @(negedge clk);
        transfer(1'b0, TD + 8, "R9 recovery");

        // R10: chip select low isolates the host side
        chip_sel = 1'b0;
        @(negedge clk); host_ext = 1'b1;
        hit = 0;
        for (int i = 0; i < 4 * TD; i++) begin
            @(negedge clk);
            if (card_drive_low || card_boost) hit = 1;
        end
        check(!hit, "R10 host low copied while deselected", hit, 0);
        host_ext = 1'b0;
        repeat (3) @(negedge clk);
        card_ext = 1'b1;
        hit = 0;
        for (int i = 0; i < 3 * TD; i++) begin
            @(negedge clk);
            if (host_drive_low || host_boost) hit = 1;
        end
        card_ext = 1'b0;
        for (int i = 0; i < 2 * TD; i++) begin
            @(negedge clk);
            if (host_drive_low || host_boost) hit = 1;
        end
        check(!hit, "R10 host driven while deselected", hit, 0);
        chip_sel = 1'b1;
        repeat (5) @(negedge clk);

        // R11: session drop mid-transfer
        @(negedge clk); host_ext = 1'b1;
        repeat (TD + 6) @(negedge clk);
        check(card_drive_low == 1'b1, "R11 copy before drop", card_drive_low, 1);
        session_en = 1'b0;
        @(negedge clk); host_ext = 1'b0;
        repeat (TD + 5) @(negedge clk);
        check(outs() == 4'b0010, "R11 held low while off", outs(), 4'b0010);
        session_en = 1'b1;
        repeat (6) @(negedge clk);
        check(outs() == 0, "R11 rest after session back", outs(), 0);

        // R12: constrained random back-to-back transfers
        for (int n = 0; n < 40; n++) begin
            bit dir = 1'($urandom_range(0, 1));
            int len = TD + 5 + int'($urandom_range(0, 60));
            transfer(dir, len, dir ? "R12 R3 random" : "R12 R4 random");
            repeat (int'($urandom_range(0, 15))) @(negedge clk);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule